// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block chooses the system clock after any reset or any wake from sleep. A crystal-type primary oscillator needs time before its output can be trusted, so the controller feeds the core from an internal oscillator at once. In parallel, a cycle counter in the primary domain confirms that the primary is stable. When the count ends, the controller moves the system clock over to the primary without a glitch and raises a status flag that software can read.

The internal source can be slowed by a 3-bit rate field. Software sets this field after reset, or before it enters sleep. If software requests sleep while the core is still on the internal clock, the controller stops the clock and never moves to the primary. The next reset or wake starts the whole qualification again. Primary modes that are not crystal-based skip the count and take the primary directly. If the enable bit is clear, the system clock stays quiet until the primary has been qualified.

Top module: `twospeed_clkctl`

## Requirements
- R1: After reset release with `por_done` high, or after a wake, with `cfg_enable`=1 and a crystal mode selected, `clk_sys` follows the internal source and `pri_active` reads 0.
- R2: In crystal modes 0 (low power), 1 (standard crystal) and 2 (high speed), the switch waits for OST_CYCLES primary cycles. After that count, `clk_sys` follows `clk_pri` and `pri_active` reads 1.
- R3: In mode 3 (high speed with PLL), the switch waits for a further PLL_LOCK primary cycles after OST_CYCLES.
- R4: With `cfg_enable`=0 and a crystal mode selected, `clk_sys` stays low until the count ends, then follows `clk_pri`.
- R5: Mode codes 4 to 7 are not crystal-based. For these codes the count is skipped and the primary is selected within a few internal cycles, whatever `cfg_enable` holds.
- R6: The internal source runs at `clk_int` divided by 2^(7-`ircf`). A value of 7 means no division.
- R7: After `sleep_req`, `clk_sys` stops. While asleep the block never switches to the primary, however long the primary runs.
- R8: No high or low phase of `clk_sys` is shorter than half the period of the faster source. The two source enables are never both on.
- R9: Reset and sleep entry clear `pri_active`. The count restarts from zero, so after a wake a full qualification is needed again.
- R10: While `por_done` is low, `clk_sys` stays low and `pri_active` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock |
| clk_int | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, any cause |
| por_done | input | 1 | Power-up timer finished |
| cfg_enable | input | 1 | Two-speed start-up enable configuration bit |
| pri_mode | input | 3 | Primary mode code: 0 to 3 are crystal modes, 3 uses the PLL |
| ircf | input | 3 | Internal rate select |
| sleep_req | input | 1 | Sleep request pulse, `clk_int` domain |
| wake_evt | input | 1 | Wake event pulse, `clk_int` domain |
| clk_sys | output | 1 | Selected system clock |
| pri_active | output | 1 | 1 when the primary supplies `clk_sys` |

## Verification
Qualification is run under high-speed mode, under PLL mode and with a divided internal rate. Each run makes sure the status never rises before the reference count of primary edges, so a shortened count or a missing PLL interval is caught. The enable-clear run separates a silent wait from internal clocking. The non-crystal run separates a skipped count from a forced one. Sleep is requested both before the switch and after it: the first shows that no switch happens while asleep, and the second, through the long status-low window after wake, shows that the counter restarts. The phase-width monitor runs through every handover and picks up runt pulses.

// File: rtl/twospeed_clkctl.sv
`timescale 1ns/1ps
module twospeed_clkctl #(
  parameter int OST_CYCLES = 1024,
  parameter int PLL_LOCK   = 64
) (
  input  logic       clk_pri,
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       por_done,
  input  logic       cfg_enable,
  input  logic [2:0] pri_mode,
  input  logic [2:0] ircf,
  input  logic       sleep_req,
  input  logic       wake_evt,
  output logic       clk_sys,
  output logic       pri_active
);
  localparam int MAX_CNT = OST_CYCLES + PLL_LOCK;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] TGT_XTAL = CNT_W'(OST_CYCLES);
  localparam logic [CNT_W-1:0] TGT_PLL  = CNT_W'(MAX_CNT);

  logic asleep, qual, is_xtal, is_pll, ready, want_pri, want_int;
  assign is_xtal = (pri_mode <= 3'd3);
  assign is_pll  = (pri_mode == 3'd3);
  assign qual    = por_done & ~asleep;

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n)         asleep <= 1'b0;
    else if (wake_evt)  asleep <= 1'b0;
    else if (sleep_req) asleep <= 1'b1;

  // start-up count in the primary domain
  logic [1:0] run_s;
  logic [CNT_W-1:0] ost_cnt;
  logic ost_done;
  logic [CNT_W-1:0] tgt;
  assign tgt = is_pll ? TGT_PLL : TGT_XTAL;

  always_ff @(posedge clk_pri or negedge rst_n)
    if (!rst_n) run_s <= '0;
    else        run_s <= {run_s[0], qual};

  always_ff @(posedge clk_pri or negedge rst_n)
    if (!rst_n) begin
      ost_cnt  <= '0;
      ost_done <= 1'b0;
    end else if (!run_s[1]) begin
      ost_cnt  <= '0;
      ost_done <= 1'b0;
    end else if (!ost_done) begin
      ost_cnt <= ost_cnt + 1'b1;
      if (ost_cnt == tgt - 1'b1) ost_done <= 1'b1;
    end

  logic [1:0] done_s;
  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n)     done_s <= '0;
    else if (!qual) done_s <= '0;
    else            done_s <= {done_s[0], ost_done};

  assign ready    = is_xtal ? done_s[1] : 1'b1;
  assign want_pri = qual & ready;
  assign want_int = qual & cfg_enable & is_xtal & ~ready;

  // internal rate postscaler
  logic [7:0] div_cnt;
  logic [2:0] tap;
  logic clk_isrc;
  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  assign tap      = 3'd6 - ircf;
  assign clk_isrc = (ircf == 3'd7) ? clk_int : div_cnt[tap];

  // glitch-free source switch
  logic [1:0] isel_s, psel_s;
  logic en_int, en_pri;

  always_ff @(posedge clk_isrc or negedge rst_n)
    if (!rst_n) isel_s <= '0;
    else        isel_s <= {isel_s[0], want_int & ~en_pri};
  always_ff @(negedge clk_isrc or negedge rst_n)
    if (!rst_n) en_int <= 1'b0;
    else        en_int <= isel_s[1];

  always_ff @(posedge clk_pri or negedge rst_n)
    if (!rst_n) psel_s <= '0;
    else        psel_s <= {psel_s[0], want_pri & ~en_int};
  always_ff @(negedge clk_pri or negedge rst_n)
    if (!rst_n) en_pri <= 1'b0;
    else        en_pri <= psel_s[1];

  assign clk_sys = (clk_isrc & en_int) | (clk_pri & en_pri);

  logic [1:0] act_s;
  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) act_s <= '0;
    else        act_s <= {act_s[0], en_pri};
  assign pri_active = act_s[1];
endmodule

// File: rtl/twospeed_clkctl_chk.sv
`timescale 1ns/1ps
module twospeed_clkctl_chk (
  input logic clk_int,
  input logic rst_n,
  input logic por_done,
  input logic asleep,
  input logic is_xtal,
  input logic done_sync,
  input logic en_int,
  input logic en_pri,
  input logic pri_active
);
  a_r8_one_source: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(en_int && en_pri));

  a_r7_no_primary_asleep: assert property (@(posedge clk_int) disable iff (!rst_n)
    asleep && $past(asleep, 8) |-> !en_pri);

  a_r9_status_clear_asleep: assert property (@(posedge clk_int) disable iff (!rst_n)
    asleep && $past(asleep, 8) |-> !pri_active);

  a_r2_switch_after_count: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(pri_active) && is_xtal |-> done_sync);

  a_r10_hold_before_por: assert property (@(posedge clk_int) disable iff (!rst_n)
    !por_done && ($past(por_done, 8) == 1'b0) |-> !en_int && !en_pri);
endmodule

bind twospeed_clkctl twospeed_clkctl_chk u_chk (
  .clk_int    (clk_int),
  .rst_n      (rst_n),
  .por_done   (por_done),
  .asleep     (asleep),
  .is_xtal    (is_xtal),
  .done_sync  (done_s[1]),
  .en_int     (en_int),
  .en_pri     (en_pri),
  .pri_active (pri_active)
);

// File: tb/sim_twospeed_clkctl.sv
`timescale 1ns/1ps
module sim_twospeed_clkctl;
  localparam int OST = 1024;
  localparam int PLL = 64;

  logic clk_pri = 0, clk_int = 0, rst_n = 0, por_done = 0, cfg_enable = 1;
  logic [2:0] pri_mode = 3'd2, ircf = 3'd7;
  logic sleep_req = 0, wake_evt = 0;
  logic clk_sys, pri_active;

  int checks = 0, errors = 0;

  twospeed_clkctl #(.OST_CYCLES(OST), .PLL_LOCK(PLL)) u0 (
    .clk_pri(clk_pri), .clk_int(clk_int), .rst_n(rst_n), .por_done(por_done),
    .cfg_enable(cfg_enable), .pri_mode(pri_mode), .ircf(ircf),
    .sleep_req(sleep_req), .wake_evt(wake_evt),
    .clk_sys(clk_sys), .pri_active(pri_active));

  always #10 clk_int = ~clk_int;
  initial begin #3; forever #7 clk_pri = ~clk_pri; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_asleep = 0;
  int pcnt = 0;
  function automatic bit m_qual();
    return rst_n && por_done && !m_asleep;
  endfunction
  always @(posedge clk_pri)
    if (!m_qual()) pcnt = 0; else pcnt++;

  int age = 0;
  bit prev_e = 0;
  always @(negedge clk_int) begin
    if (!rst_n) begin
      age = 0; prev_e = 0;
    end else begin
      bit xtal, e;
      int tgt, lag;
      string tag;
      xtal = (pri_mode <= 3'd3);
      tgt  = (pri_mode == 3'd3) ? OST + PLL : OST;
      lag  = 12 + 4 * (1 << (7 - ircf));
      e = m_qual() && (!xtal || pcnt >= tgt);
      if (e != prev_e) age = 0; else if (age < 1000000) age++;
      prev_e = e;
      if (!por_done)         tag = "R10";
      else if (m_asleep)     tag = "R7";
      else if (!xtal)        tag = "R5";
      else if (e)            tag = "R8";
      else if (pri_mode == 3'd3) tag = "R3";
      else                   tag = "R2";
      if (age >= lag) chk(pri_active == e, tag, int'(pri_active), int'(e));
    end
  end

  // phase-width monitor and edge counter
  int n_edges = 0;
  realtime last_edge = -1.0;
  always @(negedge rst_n) last_edge = -1.0;
  always @(clk_sys) begin
    if (rst_n) begin
      if (last_edge >= 0.0)
        chk(($realtime - last_edge) >= 6.9, "R8 phase width",
            int'($realtime - last_edge), 7);
      last_edge = $realtime;
    end
    if (clk_sys) n_edges++;
  end

  task automatic icyc(input int n);
    repeat (n) @(negedge clk_int);
  endtask

  task automatic measure(output int p);
    realtime t0;
    @(posedge clk_sys); t0 = $realtime;
    @(posedge clk_sys); p = int'($realtime - t0);
  endtask

  task automatic start(input logic [2:0] mode, input logic en, input logic [2:0] rate);
    @(negedge clk_int);
    rst_n = 0; por_done = 0; m_asleep = 0;
    pri_mode = mode; cfg_enable = en; ircf = rate;
    icyc(5);
    rst_n = 1;
    icyc(3);
    por_done = 1;
  endtask

  task automatic wait_active(input string tag);
    int n = 0;
    while (!pri_active && n < 4000) begin icyc(1); n++; end
    chk(pri_active == 1'b1, tag, int'(pri_active), 1);
  endtask

  task automatic do_sleep();
    @(negedge clk_int); sleep_req = 1; m_asleep = 1;
    @(negedge clk_int); sleep_req = 0;
  endtask

  task automatic do_wake();
    @(negedge clk_int); wake_evt = 1; m_asleep = 0;
    @(negedge clk_int); wake_evt = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p, e0;
    // R10: power-up timer pending
    icyc(5);
    chk(pri_active == 1'b0, "R9 reset state", int'(pri_active), 0);
    rst_n = 1;
    e0 = n_edges;
    icyc(60);
    chk(n_edges == e0, "R10 no clock before por_done", n_edges - e0, 0);
    chk(pri_active == 1'b0, "R10 status low", int'(pri_active), 0);
    por_done = 1;
    icyc(30);
    measure(p);
    chk(p == 20, "R1 internal period", p, 20);
    chk(pri_active == 1'b0, "R1 status low on internal", int'(pri_active), 0);
    wait_active("R2 switch to primary");
    icyc(10);
    measure(p);
    chk(p == 14, "R2 primary period", p, 14);

    // R3: PLL mode
    start(3'd3, 1'b1, 3'd7);
    while (pcnt < OST + PLL / 2) icyc(1);
    chk(pri_active == 1'b0, "R3 still internal in lock window", int'(pri_active), 0);
    wait_active("R3 switch after lock");

    // R6: divided internal rate
    start(3'd2, 1'b1, 3'd5);
    icyc(40);
    measure(p);
    chk(p == 80, "R6 divided internal period", p, 80);
    wait_active("R6 later switch");
    icyc(10);
    measure(p);
    chk(p == 14, "R6 primary period after divided", p, 14);

    // R7: sleep before expiry
    start(3'd1, 1'b1, 3'd7);
    icyc(200);
    do_sleep();
    icyc(20);
    e0 = n_edges;
    icyc(900);
    chk(n_edges == e0, "R7 clock stopped asleep", n_edges - e0, 0);
    chk(pri_active == 1'b0, "R7 no switch asleep", int'(pri_active), 0);
    do_wake();
    icyc(30);
    measure(p);
    chk(p == 20, "R1 internal after wake", p, 20);
    wait_active("R7 switch after wake");

    // R9: sleep while on primary, count restarts
    do_sleep();
    icyc(20);
    chk(pri_active == 1'b0, "R9 status cleared on sleep", int'(pri_active), 0);
    do_wake();
    icyc(500);
    chk(pri_active == 1'b0, "R9 count restarted", int'(pri_active), 0);
    wait_active("R9 switch after full count");

    // R4: enable clear with crystal
    start(3'd1, 1'b0, 3'd7);
    icyc(10);
    e0 = n_edges;
    icyc(200);
    chk(n_edges == e0, "R4 silent while qualifying", n_edges - e0, 0);
    wait_active("R4 switch");
    icyc(10);
    measure(p);
    chk(p == 14, "R4 primary period", p, 14);

    // R5: non-crystal mode
    start(3'd4, 1'b1, 3'd7);
    icyc(30);
    chk(pri_active == 1'b1, "R5 primary without count", int'(pri_active), 1);
    measure(p);
    chk(p == 14, "R5 primary period", p, 14);
    start(3'd6, 1'b0, 3'd7);
    icyc(30);
    chk(pri_active == 1'b1, "R5 enable ignored", int'(pri_active), 1);

    icyc(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule